// File: doc/BRIEF.md
# I2C Bus Clear Sequencer

This engine frees an I2C bus that has been left stalled by a slave holding SDA low, typically because a transfer was cut off just before an acknowledge. A single start pulse launches a sequence that toggles SCL through a fixed number of full clock cycles, at a half-period given in system clock cycles. Each cycle gives the stuck slave one more chance to finish shifting and let go of SDA.

Both lines are handled strictly as open-drain signals. The outputs are pull-down enables: 1 pulls the wire low and 0 releases it to the pull-up. The engine never drives a one. SDA is never pulled at all. The line inputs are read back through a two-flop synchronizer.

The sequence opens with SCL released for one half period. It then issues full low-then-high clock cycles, so that no half clock is lost at either end of the run. At the close of each SCL-high phase, SDA can be sampled. When polling is enabled and SDA is found high, the run stops early. The run always finishes with SCL released and reports either success or failure.

Top module: `bus_clear_seq`

## Requirements
- R1: A start pulse while idle makes busy high on the next clock. The first phase keeps SCL released (`scl_pull_o`=0) for exactly one half period.
- R2: The opening phase is followed by clock cycles, each made of a pulled-low phase and then a released phase, with every level held for one half period. With polling off, exactly 9 cycles (NUM_CYCLES) are issued, and busy lasts half*(1+2*cycles) clocks.
- R3: A programmed half period of 0 behaves exactly like a half period of 1.
- R4: With polling on (`skip_poll_i`=0), SDA is sampled through the two-flop synchronizer in the last clock of every SCL-high phase that follows a low phase. If SDA reads 1 there, the run ends after that phase with success. A release seen by the synchronizer before that last clock counts.
- R5: When the last cycle completes, the outcome is success if SDA read 1 at the final sample, otherwise failure. Exactly one of `success_o` and `fail_o` is high after a run.
- R6: `sda_pull_o` is never asserted. `scl_pull_o` is 0 whenever the engine is idle, including right after a run.
- R7: A start pulse while busy is ignored: the cycle count and the duration of the run are unchanged.
- R8: `done_o` is a one-clock pulse in the first clock where busy is low after a run. `success_o` and `fail_o` hold their values until the next start.
- R9: After reset the engine is idle: busy, done, success, fail and both pull enables are 0.
- R10: The half period and the polling control are captured at start. Changes to them during a run have no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| half_period_i | input | HP_W | SCL half period in clocks (0 acts as 1) |
| skip_poll_i | input | 1 | 1: issue all cycles without SDA early exit |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| scl_pull_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it (always 0) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-clock end-of-run pulse |
| success_o | output | 1 | Last run freed SDA |
| fail_o | output | 1 | Last run ended with SDA still low |

## Verification
The hardest case to reach from the ports is a slave that lets go of SDA at one particular SCL rising edge. Only such a slave shows whether the early exit happens after the right cycle, and whether a release one cycle too late is still reported as failure. The bench therefore models the slave as a counter of SCL rising edges on the wired-AND bus. It releases SDA after a chosen edge count, which places the release before the first sample, at a middle cycle, exactly at the ninth cycle, or never within reach. Start requests and changes to the half period are injected in the middle of a run to show that the sequence holds its shape.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_LOW  = 2'd2,
    ST_HIGH = 2'd3
  } bcs_state_e;

  // A high phase closes the run when polling found SDA free or the count is used up.
  function automatic logic run_closes(input logic skip_poll, input logic sda_high,
                                      input logic last_cycle);
    return (!skip_poll && sda_high) || last_cycle;
  endfunction

  // Total run length in clocks for a given effective half period and cycle count.
  function automatic int unsigned run_length(input int unsigned half_eff,
                                             input int unsigned cycles);
    return half_eff * (1 + 2 * cycles);
  endfunction

endpackage

// File: rtl/bcs_line_sync.sv
module bcs_line_sync #(
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= RESET_VAL;
        else if (g == 0) chain_q[g] <= din;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/bcs_half_timer.sv
module bcs_half_timer #(
  parameter int HP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [HP_W-1:0] half_i,
  input  logic            run_i,
  output logic            expire_o
);
  logic [HP_W-1:0] half_q;
  logic [HP_W-1:0] cnt_q;
  logic [HP_W-1:0] half_eff;

  assign half_eff = (half_i == '0) ? HP_W'(1) : half_i;
  assign expire_o = run_i && (cnt_q == HP_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= HP_W'(1);
      cnt_q  <= HP_W'(1);
    end else if (load_i) begin
      half_q <= half_eff;
      cnt_q  <= half_eff;
    end else if (run_i) begin
      if (cnt_q == HP_W'(1)) cnt_q <= half_q;
      else cnt_q <= cnt_q - HP_W'(1);
    end
  end
endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
#(
  parameter int NUM_CYCLES = 9,
  localparam int PW = $clog2(NUM_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          skip_poll_i,
  input  logic          sda_s_i,
  input  logic          phase_end_i,
  output logic          launch_o,
  output logic          active_o,
  output logic          scl_pull_o,
  output logic          done_o,
  output logic          success_o,
  output logic          fail_o,
  output logic [PW-1:0] pulses_o
);
  bcs_state_e    state_q;
  logic [PW-1:0] pulses_q;
  logic          skip_q;
  logic          done_q, succ_q, fail_q;
  logic          last_cycle;
  logic          closing;

  assign launch_o   = (state_q == ST_IDLE) && start_i;
  assign active_o   = (state_q != ST_IDLE);
  assign last_cycle = (pulses_q == PW'(NUM_CYCLES));
  assign closing    = (state_q == ST_HIGH) && phase_end_i &&
                      run_closes(skip_q, sda_s_i, last_cycle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pulses_q <= '0;
      skip_q   <= 1'b0;
      done_q   <= 1'b0;
      succ_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_LEAD;
          pulses_q <= '0;
          skip_q   <= skip_poll_i;
          succ_q   <= 1'b0;
          fail_q   <= 1'b0;
        end
        ST_LEAD: if (phase_end_i) state_q <= ST_LOW;
        ST_LOW: if (phase_end_i) begin
          state_q  <= ST_HIGH;
          pulses_q <= pulses_q + PW'(1);
        end
        ST_HIGH: if (phase_end_i) begin
          if (closing) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            succ_q  <= sda_s_i;
            fail_q  <= !sda_s_i;
          end else begin
            state_q <= ST_LOW;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign scl_pull_o = (state_q == ST_LOW);
  assign done_o     = done_q;
  assign success_o  = succ_q;
  assign fail_o     = fail_q;
  assign pulses_o   = pulses_q;
endmodule

// File: rtl/bus_clear_seq.sv
module bus_clear_seq #(
  parameter int HP_W        = 16,
  parameter int NUM_CYCLES  = 9,
  parameter int SYNC_STAGES = 2,
  localparam int PW = $clog2(NUM_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [HP_W-1:0] half_period_i,
  input  logic            skip_poll_i,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            scl_pull_o,
  output logic            sda_pull_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            success_o,
  output logic            fail_o
);
  // Named internal events, used by the bound checker.
  logic          scl_s_w;
  logic          sda_s_w;
  logic          launch_w;
  logic          active_w;
  logic          phase_end_w;
  logic [PW-1:0] pulses_w;

  bcs_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_s_w)
  );

  bcs_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_s_w)
  );

  bcs_half_timer #(.HP_W(HP_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(launch_w), .half_i(half_period_i),
    .run_i(active_w), .expire_o(phase_end_w)
  );

  bcs_ctrl #(.NUM_CYCLES(NUM_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .skip_poll_i(skip_poll_i),
    .sda_s_i(sda_s_w), .phase_end_i(phase_end_w), .launch_o(launch_w),
    .active_o(active_w), .scl_pull_o(scl_pull_o), .done_o(done_o),
    .success_o(success_o), .fail_o(fail_o), .pulses_o(pulses_w)
  );

  // SDA is owned only by releasing it.
  assign sda_pull_o = 1'b0;
  assign busy_o     = active_w;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int NUM_CYCLES = 9,
  localparam int PW = $clog2(NUM_CYCLES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          success_o,
  input logic          fail_o,
  input logic          scl_pull_o,
  input logic          phase_end,
  input logic [PW-1:0] pulses
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o); // R1
  AST_LEAD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !scl_pull_o); // R1
  AST_SCL_ON_PHASE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull_o != $past(scl_pull_o)) |-> $past(phase_end)); // R2
  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pulses <= PW'(NUM_CYCLES)); // R2
  AST_OUTCOME_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (success_o != fail_o)); // R5
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !scl_pull_o); // R6
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !phase_end) |=> $stable(pulses)); // R7
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o))); // R8
endmodule

bind bus_clear_seq bcs_checker #(.NUM_CYCLES(NUM_CYCLES)) u_bcs_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .success_o(success_o), .fail_o(fail_o),
  .scl_pull_o(scl_pull_o), .phase_end(phase_end_w), .pulses(pulses_w)
);

// File: tb/tb_bus_clear_seq.sv
module tb_bus_clear_seq;
  localparam int HP_W = 16;
  localparam int NCYC = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [HP_W-1:0] half = '0;
  logic skip = 1'b0;
  logic scl_pull, sda_pull, busy, done, succ, fail;
  logic slv_clr = 1'b0;
  logic [3:0] rel_k = 4'd15;
  logic [3:0] rises;
  logic scl_prev;
  logic scl_line, sda_line;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  // Wired-AND bus with pull-ups; slave frees SDA after rel_k SCL rising edges.
  assign scl_line = ~scl_pull;
  assign sda_line = (rises >= rel_k) && !sda_pull;

  always @(posedge clk) begin
    if (!rst_n || slv_clr) begin
      scl_prev <= 1'b1;
      rises    <= '0;
    end else begin
      scl_prev <= scl_line;
      if (scl_line && !scl_prev && rises != 4'd15) rises <= rises + 4'd1;
    end
  end

  bus_clear_seq #(.HP_W(HP_W), .NUM_CYCLES(NCYC)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .half_period_i(half),
    .skip_poll_i(skip), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .busy_o(busy),
    .done_o(done), .success_o(succ), .fail_o(fail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // hp, skip, release edge (15 = never), expected cycles, expected success
  typedef struct packed {
    logic [15:0] hp;
    logic        skip;
    logic [3:0]  k;
    logic [3:0]  exp_cyc;
    logic        exp_ok;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{16'd4, 1'b0, 4'd3,  4'd3, 1'b1},
    '{16'd5, 1'b1, 4'd2,  4'd9, 1'b1},
    '{16'd4, 1'b0, 4'd15, 4'd9, 1'b0},
    '{16'd0, 1'b1, 4'd15, 4'd9, 1'b0},
    '{16'd6, 1'b0, 4'd9,  4'd9, 1'b1},
    '{16'd4, 1'b0, 4'd0,  4'd1, 1'b1},
    '{16'd3, 1'b1, 4'd10, 4'd9, 1'b0}
  };

  // disturb: 0 none, 1 extra start mid-run, 2 config change mid-run
  task automatic run_case(input vec_t v, input int disturb);
    int eff, exp_len, len, lead, lows, falls, guard;
    bit seen_pull, prev_pull, sda_touched;
    eff = (v.hp == 0) ? 1 : int'(v.hp);
    exp_len = eff * (1 + 2 * int'(v.exp_cyc));
    half = v.hp; skip = v.skip; rel_k = v.k;
    @(negedge clk);
    start = 1'b1; slv_clr = 1'b1;
    @(negedge clk);
    start = 1'b0; slv_clr = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    len = 0; lead = 0; lows = 0; falls = 0; guard = 0;
    seen_pull = 0; prev_pull = 0; sda_touched = 0;
    while (busy && guard < 5000) begin
      len++; guard++;
      if (sda_pull) sda_touched = 1;
      if (scl_pull) begin
        lows++;
        if (!prev_pull) falls++;
        seen_pull = 1;
      end else if (!seen_pull) lead++;
      prev_pull = scl_pull;
      if (disturb == 1 && len == 20) start = 1'b1;
      else start = 1'b0;
      if (disturb == 2 && len == 3) begin half = 16'd9; skip = ~v.skip; end
      @(negedge clk);
    end
    start = 1'b0;
    chk(done == 1'b1, "R8 done when busy drops", done, 1);
    chk(scl_pull == 1'b0, "R6 SCL released at end", scl_pull, 0);
    chk(!sda_touched, "R6 SDA never pulled", sda_touched, 0);
    chk(lead == eff, "R1 lead released phase length", lead, eff);
    chk(falls == int'(v.exp_cyc), (v.skip ? "R2 cycle count" : "R4 cycle count"),
        falls, int'(v.exp_cyc));
    chk(lows == eff * int'(v.exp_cyc), "R2 low time", lows, eff * int'(v.exp_cyc));
    chk(len == exp_len, (v.hp == 0 ? "R3 run length" : "R2 run length"), len, exp_len);
    chk(succ == v.exp_ok && fail == !v.exp_ok, "R5 outcome", {succ, fail}, {v.exp_ok, !v.exp_ok});
    @(negedge clk);
    chk(done == 1'b0, "R8 done single pulse", done, 0);
    repeat (3) @(negedge clk);
    chk(succ == v.exp_ok && fail == !v.exp_ok, "R8 outcome held", {succ, fail}, {v.exp_ok, !v.exp_ok});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, succ, fail, scl_pull, sda_pull} == 6'b0, "R9 reset state",
        {busy, done, succ, fail, scl_pull, sda_pull}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) run_case(VECS[i], 0);
    // R7: start during a run ignored
    run_case('{16'd4, 1'b1, 4'd15, 4'd9, 1'b0}, 1);
    // R10: half period and polling captured at start (poll on, slave frees at 2)
    run_case('{16'd4, 1'b0, 4'd2, 4'd2, 1'b1}, 2);
    // R4: release at the 8th edge still stops at 8 cycles
    run_case('{16'd5, 1'b0, 4'd8, 4'd8, 1'b1}, 0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule